// File: doc/BRIEF.md
# Tri-State PWM Half-Bridge Gate Controller

This block is the digital control core of a synchronous buck half-bridge driver. It receives the two outputs of the PWM input comparators: one says the input is above the rising threshold and the other says it is below the falling threshold. It also receives an enable, a low-side permit and a supply-good flag. From these it produces the high-side and low-side gate commands. All inputs are assumed to be synchronized to `clk` already.

The PWM input is treated as three-level. A valid high turns the high-side gate on. A valid low turns the low-side gate on. A level that stays inside the hysteresis band for a programmable hold-off time is taken to be a floating line, and the block then parks both gates low in a tri-state off mode. Only a valid high ends that mode, and the block also starts in it after reset or after the supply recovers. A non-overlap stage inserts a programmable dead band at every hand-over, so that the two gates are never on together. A low-side permit input supports discontinuous conduction by keeping the low-side gate off.

Top module: `tspwm_gate_ctrl`

## Requirements
- R1: When the PWM level is valid high, the steady state is high-side gate on and low-side gate off. When it is valid low and the block is not in tri-state off, the steady state is high-side off and low-side on.
- R2: The PWM level is in the band when neither comparator output is set. After HOLD_CYC consecutive clock edges in the band, `tri_off` is 1 and both gates are driven low. A dwell of HOLD_CYC-1 edges changes nothing. Any edge outside the band restarts the count. Before the hold-off expires, the gates keep the command of the last valid level.
- R3: While in tri-state off, a valid low level does not release the block. A valid high level releases it and returns it to normal switching.
- R4: After a synchronous reset (`rst_n` low), and after `supply_ok` returns, the block is in tri-state off with both gates low. It stays there with the PWM level low or in the band until the first valid high.
- R5: With `enable` low, both gates are low from the first clock edge on. When `enable` returns high, the gates follow PWM again.
- R6: The two gates are never on in the same cycle. When one gate is turned off and the other is wanted, both gates stay low for exactly DEAD_CYC+1 cycles before the other gate turns on.
- R7: With `supply_ok` low, both gates are low from the first clock edge on and tri-state off is entered. This overrides all other inputs.
- R8: With `ls_permit` low, the low-side gate stays off while the high-side gate still follows PWM. With `ls_permit` high, the low side operates normally.
- R9: Comparator encoding: `pwm_above`=1 is a valid high whatever `pwm_below` is. `pwm_above`=0 with `pwm_below`=1 is a valid low. Both 0 means the level is in the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwm_above | input | 1 | PWM input is above the rising threshold |
| pwm_below | input | 1 | PWM input is below the falling threshold |
| enable | input | 1 | Gate activity allowed when high |
| ls_permit | input | 1 | Low-side gate allowed when high; low selects diode-emulation mode |
| supply_ok | input | 1 | Supply-good flag, active high |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| tri_off | output | 1 | Tri-state off mode is active |

## Verification
The PWM level is applied as clean high/low alternation, as band dwells of exactly HOLD_CYC-1 and HOLD_CYC edges, and as a band dwell broken by a single valid-low edge. Together these separate a correct hold-off count from one that is off by one or is never restarted. Valid-low-only and valid-high stimulus during tri-state off shows that the exit condition is asymmetric. The dual-comparator code shows the high-priority decode. Enable, low-side permit and supply drops are each applied against both PWM levels, so that each override can be told apart from plain PWM following. The measured low interval at each hand-over pins the dead band to its exact length.

// File: rtl/tspwm_pkg.sv
package tspwm_pkg;
    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_MID  = 2'd1,
        LVL_HIGH = 2'd2
    } pwm_lvl_e;

    function automatic pwm_lvl_e classify(input logic above, input logic below);
        if (above)      return LVL_HIGH;
        else if (below) return LVL_LOW;
        else            return LVL_MID;
    endfunction
endpackage

// File: rtl/tspwm_level_track.sv
module tspwm_level_track
    import tspwm_pkg::*;
#(
    parameter int HOLD_CYC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_above,
    input  logic pwm_below,
    input  logic supply_ok,
    output logic tri_off,
    output logic last_high
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(HOLD_CYC - 1);

    typedef struct packed {
        logic          tri_off;
        logic          last_high;
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t     st_d, st_q;
    pwm_lvl_e lvl;

    always_comb begin
        lvl  = classify(pwm_above, pwm_below);
        st_d = st_q;
        if (!supply_ok) begin
            st_d.tri_off   = 1'b1;
            st_d.last_high = 1'b0;
            st_d.cnt       = '0;
        end else begin
            unique case (lvl)
                LVL_HIGH: begin
                    st_d.tri_off   = 1'b0;
                    st_d.last_high = 1'b1;
                    st_d.cnt       = '0;
                end
                LVL_LOW: begin
                    st_d.last_high = 1'b0;
                    st_d.cnt       = '0;
                end
                default: begin
                    if (st_q.cnt == CNT_LAST) st_d.tri_off = 1'b1;
                    else                      st_d.cnt     = st_q.cnt + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tri_off   <= 1'b1;
            st_q.last_high <= 1'b0;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tri_off   = st_q.tri_off;
    assign last_high = st_q.last_high;

    p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && !pwm_above && !pwm_below && st_q.cnt == CNT_LAST) |=> tri_off);

    p_exit_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tri_off) |-> $past(pwm_above));

    p_supply_tri_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> tri_off);
endmodule

// File: rtl/tspwm_nonoverlap.sv
module tspwm_nonoverlap #(
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_hs,
    input  logic want_ls,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int DW = (DEAD_CYC < 1) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] GAP_FULL = DW'(DEAD_CYC);

    typedef struct packed {
        logic          hs;
        logic          ls;
        logic [DW-1:0] gap;
    } gate_t;

    gate_t st_d, st_q;
    logic  gap_ok;

    always_comb begin
        gap_ok  = (st_q.gap >= GAP_FULL);
        st_d.hs = want_hs && !want_ls && (st_q.hs || (!st_q.ls && gap_ok));
        st_d.ls = want_ls && !want_hs && (st_q.ls || (!st_q.hs && gap_ok));
        if (st_q.hs || st_q.ls) st_d.gap = '0;
        else if (!gap_ok)       st_d.gap = st_q.gap + 1'b1;
        else                    st_d.gap = st_q.gap;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hs  <= 1'b0;
            st_q.ls  <= 1'b0;
            st_q.gap <= GAP_FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign hs_gate = st_q.hs;
    assign ls_gate = st_q.ls;

    p_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    p_hs_after_ls_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_gate) |-> !$past(ls_gate));

    p_ls_after_hs_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_gate) |-> !$past(hs_gate));
endmodule

// File: rtl/tspwm_gate_ctrl.sv
module tspwm_gate_ctrl #(
    parameter int HOLD_CYC = 12,
    parameter int DEAD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_above,
    input  logic pwm_below,
    input  logic enable,
    input  logic ls_permit,
    input  logic supply_ok,
    output logic hs_gate,
    output logic ls_gate,
    output logic tri_off
);
    logic trk_tri, trk_high;
    logic run_ok, want_hs, want_ls;

    tspwm_level_track #(.HOLD_CYC(HOLD_CYC)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_above (pwm_above),
        .pwm_below (pwm_below),
        .supply_ok (supply_ok),
        .tri_off   (trk_tri),
        .last_high (trk_high)
    );

    always_comb begin
        run_ok  = supply_ok && enable && !trk_tri;
        want_hs = run_ok && trk_high;
        want_ls = run_ok && !trk_high && ls_permit;
    end

    tspwm_nonoverlap #(.DEAD_CYC(DEAD_CYC)) u_nov (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_hs (want_hs),
        .want_ls (want_ls),
        .hs_gate (hs_gate),
        .ls_gate (ls_gate)
    );

    assign tri_off = trk_tri;

    p_supply_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_gate && !ls_gate));

    p_enable_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!hs_gate && !ls_gate));

    p_ls_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ls_permit |=> !ls_gate);

    p_tri_gates_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tri_off |=> (!hs_gate && !ls_gate));
endmodule

// File: tb/tspwm_gate_ctrl_tb.sv
module tspwm_gate_ctrl_tb;
    localparam int HOLD = 12;
    localparam int DEAD = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_above = 1'b0, pwm_below = 1'b1;
    logic enable = 1'b1, ls_permit = 1'b1, supply_ok = 1'b1;
    logic hs_gate, ls_gate, tri_off;

    always #4 clk = ~clk;

    tspwm_gate_ctrl #(.HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_above(pwm_above), .pwm_below(pwm_below),
        .enable(enable), .ls_permit(ls_permit), .supply_ok(supply_ok),
        .hs_gate(hs_gate), .ls_gate(ls_gate), .tri_off(tri_off)
    );

    typedef struct {
        bit    hs;
        bit    ls;
        bit    tri_m;
        string tag;
    } exp_t;

    exp_t  exp_q[$];
    event  ev_chk;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    prev_side = 0;
    int    low_run = 0;
    int    hand_run = -1;

    // scoreboard monitor
    initial forever begin
        @(ev_chk);
        while (exp_q.size() > 0) begin
            exp_t it;
            it = exp_q.pop_front();
            checks++;
            if (hs_gate !== it.hs || ls_gate !== it.ls || tri_off !== it.tri_m) begin
                errors++;
                $display("FAIL %s: got hs=%b ls=%b tri=%b, expected hs=%b ls=%b tri=%b",
                         it.tag, hs_gate, ls_gate, tri_off, it.hs, it.ls, it.tri_m);
            end
        end
    end

    // hand-over monitor for R6
    always @(negedge clk) begin
        if (rst_n) begin
            if (hs_gate && ls_gate) begin
                checks++; errors++;
                $display("FAIL R6 overlap: got hs=1 ls=1, expected not both");
            end else if (!hs_gate && !ls_gate) begin
                low_run++;
            end else begin
                if ((hs_gate && prev_side == 2) || (ls_gate && prev_side == 1)) begin
                    hand_run = low_run;
                    checks++;
                    if (low_run < DEAD + 1) begin
                        errors++;
                        $display("FAIL R6 gap: got %0d, expected >= %0d", low_run, DEAD + 1);
                    end
                end
                prev_side = hs_gate ? 1 : 2;
                low_run = 0;
            end
        end
    end

    task automatic drive(input bit a, input bit b, input bit en, input bit lsp,
                         input bit sup, input int n, input bit ehs, input bit els,
                         input bit etri, input string tag);
        exp_t it;
        pwm_above = a; pwm_below = b; enable = en; ls_permit = lsp; supply_ok = sup;
        repeat (n) @(posedge clk);
        @(negedge clk);
        it.hs = ehs; it.ls = els; it.tri_m = etri; it.tag = tag;
        exp_q.push_back(it);
        -> ev_chk;
        #1;
    endtask

    task automatic check_gap(input string tag);
        checks++;
        if (hand_run != DEAD + 1) begin
            errors++;
            $display("FAIL %s: got gap %0d, expected %0d", tag, hand_run, DEAD + 1);
        end
    endtask

    initial begin
        exp_t it;
        repeat (3) @(posedge clk);
        @(negedge clk);
        it.hs = 0; it.ls = 0; it.tri_m = 1; it.tag = "R4 reset state";
        exp_q.push_back(it); -> ev_chk; #1;
        rst_n = 1'b1;
        // pwm encodings: high (1,0), low (0,1), band (0,0), both (1,1)
        drive(0,1,1,1,1, 20, 0,0,1, "R4 low after reset keeps tri-off");
        drive(0,0,1,1,1, 20, 0,0,1, "R4 band after reset keeps tri-off");
        drive(1,0,1,1,1, 20, 1,0,0, "R3 high releases, R1 high side on");
        drive(0,1,1,1,1, 20, 0,1,0, "R1 low side on");
        check_gap("R6 hs to ls hand-over");
        drive(1,0,1,1,1, 20, 1,0,0, "R1 high side on again");
        check_gap("R6 ls to hs hand-over");
        drive(0,1,1,1,1, 20, 0,1,0, "R1 low before dual code");
        drive(1,1,1,1,1, 20, 1,0,0, "R9 both comparators decode as high");
        drive(0,1,1,1,1, 20, 0,1,0, "R9 low-only decodes as low");
        drive(0,0,1,1,1, HOLD-1, 0,1,0, "R2 dwell one short keeps gates");
        drive(0,1,1,1,1, 1, 0,1,0, "R2 single low edge");
        drive(0,0,1,1,1, HOLD-1, 0,1,0, "R2 count restarted after low");
        drive(0,1,1,1,1, 3, 0,1,0, "R2 no trip after interrupted dwell");
        drive(0,0,1,1,1, HOLD, 0,1,1, "R2 trip on hold-off edge");
        drive(0,0,1,1,1, 3, 0,0,1, "R2 gates low in tri-off");
        drive(0,1,1,1,1, 20, 0,0,1, "R3 low does not release");
        drive(1,0,1,1,1, 20, 1,0,0, "R3 high releases");
        drive(1,0,0,1,1, 1, 0,0,0, "R5 enable low forces off next edge");
        drive(1,0,0,1,1, 20, 0,0,0, "R5 enable low holds off");
        drive(1,0,1,1,1, 20, 1,0,0, "R5 enable high follows high");
        drive(0,1,0,1,1, 20, 0,0,0, "R5 enable low with low level");
        drive(0,1,1,1,1, 20, 0,1,0, "R5 enable high follows low");
        drive(0,1,1,0,1, 1, 0,0,0, "R8 permit low blocks low side");
        drive(1,0,1,0,1, 20, 1,0,0, "R8 high side still follows");
        drive(0,1,1,0,1, 20, 0,0,0, "R8 low level with low side blocked");
        drive(0,1,1,1,1, 20, 0,1,0, "R8 permit high restores low side");
        drive(1,0,1,1,1, 20, 1,0,0, "R1 high before supply drop");
        drive(1,0,1,1,0, 1, 0,0,1, "R7 supply drop overrides high");
        drive(0,1,1,1,0, 20, 0,0,1, "R7 supply low holds off");
        drive(0,1,1,1,1, 20, 0,0,1, "R4 supply return stays tri-off");
        drive(1,0,1,1,1, 20, 1,0,0, "R4 first high after supply return");
        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R1: got timeout, expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule